// File: doc/BRIEF.md
# Two-Dimensional Memory Copy Engine

This block copies data between two memory regions with no processor in the loop. A fetch stream reads elements over a synchronous read port. A store stream writes the same elements, in the same order, over a write port. A small elastic queue sits between the two streams. Each stream walks its own address pattern. An inner loop moves by a signed inner step. When a row ends, a signed row step replaces the inner step for that move. This lets the engine copy a rectangle out of one frame into a frame of another width. A row step may also run backwards.

Software programs both streams through a small register port. It arms the fetch stream first and the store stream second. It then waits for the store stream's done flag, or for that stream's interrupt. Each stream has its own done, error and busy status bits. Done and error are cleared by writing 1 to them. Any request that the engine cannot run is refused, and the refusal raises the error flag.

Top module: `dma2d_top`

## Requirements
- R1: Register map. The register address is `{stream, index[2:0]}`, where stream 0 is fetch and stream 1 is store. The index values are: 0 base address, 1 inner count, 2 inner step, 3 row count, 4 row step, 5 control, 6 status. The control bits are: bit 0 arm, bit 1 two-dimensional mode, bit 2 write direction, bits 5:4 element size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The status bits are: bit 0 done, bit 1 error, bit 2 busy. After reset, every register and status bit reads 0, and no read or write request is issued.
- R2: In two-dimensional mode, a stream visits inner count times row count addresses, starting at the base. After each element that is not last in its row, the sign-extended inner step is added to the address. After the last element of a row, the sign-extended row step is added instead.
- R3: With bit 1 clear, the row count and row step have no effect. A row count of 0 is accepted, and exactly one row is moved.
- R4: Steps are signed 16-bit byte offsets. Addresses wrap modulo 2^32.
- R5: Each store write carries the word returned by the read port for the matching fetch element, in order. The read data is taken one cycle after `rd_req_o`.
- R6: An arm request is refused, the error flag is set, and no data moves, in any of these cases: the inner count is 0; the row count is 0 in two-dimensional mode; the element size is 3; the base address is not a multiple of the element size; or bit 2 differs from the stream number (store streams need it set, fetch streams need it clear).
- R7: A control write while a stream is busy is ignored: the control readback and the running transfer are unchanged, and the error flag is set. Parameter register writes are also ignored while the stream is busy.
- R8: Busy rises after a successful arm. It falls with done set in the same cycle in which the stream's final element is issued. Writing 1 to done or error clears that flag.
- R9: When completion and a done-clearing write fall in the same cycle, done ends up set.
- R10: `irq_o[s]` is high exactly while stream s has its done flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {stream, index} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read byte address |
| rd_data_i | input | 32 | Read data, valid one cycle after the request |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 32 | Memory write byte address |
| wr_data_o | output | 32 | Memory write data |
| wr_size_o | output | 2 | Store-stream element size code |
| irq_o | output | 2 | Per-stream done interrupt level |

## Verification
The store stream's completion can fall in the same cycle as a software write that clears its done flag. To provoke this, the bench first lets a one-element fetch finish, so the queue already holds the element. It then arms the store stream and writes the clear in the very next cycle, which is the cycle in which the store issues its only write. It reads status afterwards and expects done still set with the interrupt high. A second clear is then expected to drop both.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [2:0] {
    IDX_BASE = 3'd0,
    IDX_XCNT = 3'd1,
    IDX_XSTP = 3'd2,
    IDX_YCNT = 3'd3,
    IDX_YSTP = 3'd4,
    IDX_CTRL = 3'd5,
    IDX_STAT = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic [1:0] size;
    logic       rsv;
    logic       wnr;
    logic       two_d;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          two_d_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic [CW-1:0] xstp_i,
  input  logic [CW-1:0] ycnt_i,
  input  logic [CW-1:0] ystp_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [CW-1:0] xrem_q, yrem_q;
  logic [AW-1:0] xinc, yinc;

  assign xinc   = {{(AW-CW){xstp_i[CW-1]}}, xstp_i};
  assign yinc   = {{(AW-CW){ystp_i[CW-1]}}, ystp_i};
  assign last_o = (xrem_q == CW'(1)) && (yrem_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      xrem_q <= '0;
      yrem_q <= '0;
    end else if (load_i) begin
      addr_o <= base_i;
      xrem_q <= xcnt_i;
      yrem_q <= two_d_i ? ycnt_i : CW'(1);
    end else if (step_i) begin
      if (xrem_q == CW'(1)) begin
        // row end: row step replaces inner step
        xrem_q <= xcnt_i;
        yrem_q <= yrem_q - CW'(1);
        addr_o <= addr_o + yinc;
      end else begin
        xrem_q <= xrem_q - CW'(1);
        addr_o <= addr_o + xinc;
      end
    end
  end
endmodule

// File: rtl/dma2d_fifo.sv
module dma2d_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   din_i,
  input  logic            pop_i,
  output logic [DW-1:0]   dout_o,
  output logic [CNTW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;

  assign dout_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= din_i;
        wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + PW'(1);
      end
      if (pop_i) rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + PW'(1);
      cnt_o <= cnt_o + CNTW'(push_i) - CNTW'(pop_i);
    end
  end
endmodule

// File: rtl/dma2d_top.sv
module dma2d_top
  import dma2d_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [1:0]    wr_size_o,
  output logic [1:0]    irq_o
);
  logic [1:0]      run_q, done_q, err_q, step, last;
  logic [AW-1:0]   addr [2];
  logic [CNTW-1:0] fifo_cnt;
  logic            rd_vld_q;
  logic [2:0]      idx;
  ctrl_t           ctrl_w;

  assign idx    = reg_addr_i[2:0];
  assign ctrl_w = ctrl_t'(reg_wdata_i[5:0]);

  // fetch only when queue has room counting the read in flight
  assign step[0] = run_q[0] && ((CNTW+1)'(fifo_cnt) + (CNTW+1)'(rd_vld_q) < (CNTW+1)'(DEPTH));
  assign step[1] = run_q[1] && (fifo_cnt != '0);

  for (genvar s = 0; s < 2; s++) begin : g_s
    logic [AW-1:0] base_r;
    logic [CW-1:0] xcnt_r, xstp_r, ycnt_r, ystp_r;
    ctrl_t         ctrl_r;
    logic          run_r, done_r, err_r;
    logic          sel, wr_ctrl, wr_stat, misal, bad, go;
    logic [31:0]   rd_w;

    assign sel     = reg_wr_i && (reg_addr_i[3] == 1'(s));
    assign wr_ctrl = sel && (idx == IDX_CTRL);
    assign wr_stat = sel && (idx == IDX_STAT);

    always_comb begin
      misal = ((ctrl_w.size == 2'd1) && base_r[0]) ||
              ((ctrl_w.size == 2'd2) && (base_r[1:0] != 2'b00));
      bad   = (xcnt_r == '0) || (ctrl_w.two_d && (ycnt_r == '0)) || misal ||
              (ctrl_w.size == 2'd3) || (ctrl_w.wnr != 1'(s));
      go    = wr_ctrl && !run_r && ctrl_w.en && !bad;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_r <= '0; xcnt_r <= '0; xstp_r <= '0; ycnt_r <= '0; ystp_r <= '0;
        ctrl_r <= '0; run_r <= 1'b0; done_r <= 1'b0; err_r <= 1'b0;
      end else begin
        if (sel && !run_r) begin
          case (idx)
            IDX_BASE: base_r <= reg_wdata_i[AW-1:0];
            IDX_XCNT: xcnt_r <= reg_wdata_i[CW-1:0];
            IDX_XSTP: xstp_r <= reg_wdata_i[CW-1:0];
            IDX_YCNT: ycnt_r <= reg_wdata_i[CW-1:0];
            IDX_YSTP: ystp_r <= reg_wdata_i[CW-1:0];
            default: ;
          endcase
        end
        if (wr_ctrl) begin
          if (run_r) err_r <= 1'b1;
          else begin
            ctrl_r <= ctrl_w;
            if (ctrl_w.en && bad) err_r <= 1'b1;
            if (go) run_r <= 1'b1;
          end
        end
        if (wr_stat) begin
          if (reg_wdata_i[0]) done_r <= 1'b0;
          if (reg_wdata_i[1]) err_r  <= 1'b0;
        end
        // completion after clear: set wins
        if (step[s] && last[s]) begin
          run_r  <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end

    dma2d_walker #(.AW(AW), .CW(CW)) u_walk (
      .clk_i, .rst_ni,
      .load_i (go),
      .step_i (step[s]),
      .two_d_i(ctrl_w.two_d),
      .base_i (base_r),
      .xcnt_i (xcnt_r),
      .xstp_i (xstp_r),
      .ycnt_i (ycnt_r),
      .ystp_i (ystp_r),
      .addr_o (addr[s]),
      .last_o (last[s])
    );

    always_comb begin
      case (idx)
        IDX_BASE: rd_w = 32'(base_r);
        IDX_XCNT: rd_w = 32'(xcnt_r);
        IDX_XSTP: rd_w = 32'(xstp_r);
        IDX_YCNT: rd_w = 32'(ycnt_r);
        IDX_YSTP: rd_w = 32'(ystp_r);
        IDX_CTRL: rd_w = 32'(ctrl_r);
        IDX_STAT: rd_w = {29'd0, run_r, err_r, done_r};
        default:  rd_w = '0;
      endcase
    end

    assign run_q[s]  = run_r;
    assign done_q[s] = done_r;
    assign err_q[s]  = err_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= step[0];
  end

  dma2d_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(rd_vld_q),
    .din_i (rd_data_i),
    .pop_i (step[1]),
    .dout_o(wr_data_o),
    .cnt_o (fifo_cnt)
  );

  assign reg_rdata_o = reg_addr_i[3] ? g_s[1].rd_w : g_s[0].rd_w;
  assign rd_req_o    = step[0];
  assign rd_addr_o   = addr[0];
  assign wr_en_o     = step[1];
  assign wr_addr_o   = addr[1];
  assign wr_size_o   = g_s[1].ctrl_r.size;
  assign irq_o       = done_q;
endmodule

// File: rtl/dma2d_chk.sv
module dma2d_chk #(
  parameter int CNTW  = 3,
  parameter int DEPTH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_req_o,
  input logic            wr_en_o,
  input logic [1:0]      irq_o,
  input logic [1:0]      run_q,
  input logic [1:0]      done_q,
  input logic [CNTW-1:0] fifo_cnt
);
  assert_rd_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> run_q[0]);
  assert_wr_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> run_q[1]);
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fifo_cnt) <= DEPTH);
  assert_irq_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[1]) |-> $past(run_q[1]));
  assert_busy_ends_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q[1]) |-> done_q[1]);
  assert_wr_needs_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (fifo_cnt != '0));
endmodule

bind dma2d_top dma2d_chk #(.CNTW(CNTW), .DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_req_o(rd_req_o),
  .wr_en_o (wr_en_o),
  .irq_o   (irq_o),
  .run_q   (run_q),
  .done_q  (done_q),
  .fifo_cnt(fifo_cnt)
);

// File: tb/tb_dma2d_top.sv
module tb_dma2d_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic [31:0] rd_data_i = '0;
  logic        wr_en_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic [1:0]  wr_size_o, irq_o;

  int n_run = 0, n_fail = 0, n_wr = 0;
  logic [63:0] exp_q[$];
  logic [31:0] sa_q[$], da_q[$];

  always #4 clk_i = ~clk_i;

  dma2d_top dut (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3C3_3C3C;
  endfunction

  always @(posedge clk_i) if (rd_req_o) rd_data_i <= pat(rd_addr_o);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop
  always @(negedge clk_i) begin
    if (rst_ni && wr_en_o) begin
      n_wr++;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected write", {wr_addr_o, wr_data_o}, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk({wr_addr_o, wr_data_o} == e, "R2/R4/R5 write", {wr_addr_o, wr_data_o}, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic prog(input bit s, input logic [31:0] b, input logic [15:0] xc, xs, yc, ys);
    wr({s, 3'd0}, b);
    wr({s, 3'd1}, 32'(xc));
    wr({s, 3'd2}, 32'(xs));
    wr({s, 3'd3}, 32'(yc));
    wr({s, 3'd4}, 32'(ys));
  endtask

  // independent address model from R2-R4
  task automatic gen(input bit dst, input logic [31:0] b, input int xc, input logic [15:0] xs,
                     input int yc, input logic [15:0] ys, input bit d2);
    logic [31:0] a;
    int rows;
    a = b;
    rows = d2 ? yc : 1;
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < xc; x++) begin
        if (dst) da_q.push_back(a); else sa_q.push_back(a);
        a = a + ((x == xc-1) ? {{16{ys[15]}}, ys} : {{16{xs[15]}}, xs});
      end
  endtask

  task automatic pair();
    while (sa_q.size() > 0 && da_q.size() > 0)
      exp_q.push_back({da_q.pop_front(), pat(sa_q.pop_front())});
  endtask

  task automatic wait_done(input bit s);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd({s, 3'd6}, v);
      if (v[0]) break;
    end
  endtask

  task automatic clr();
    wr(4'h6, 32'd3);
    wr(4'hE, 32'd3);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!rd_req_o && !wr_en_o && irq_o == 2'b00, "R1 reset outputs", {rd_req_o, wr_en_o, irq_o}, 0);
    rst_ni = 1'b1;
    rd(4'h6, v); chk(v == 0, "R1 fetch status", v, 0);
    rd(4'hE, v); chk(v == 0, "R1 store status", v, 0);
    rd(4'h5, v); chk(v == 0, "R1 ctrl", v, 0);

    // R2 two-dimensional copy into wider frame
    gen(0, 32'h100, 3, 16'd2, 2, 16'd2, 1);
    gen(1, 32'h1000, 3, 16'd2, 2, 16'h10, 1);
    pair();
    prog(0, 32'h100, 3, 2, 2, 2);
    prog(1, 32'h1000, 3, 2, 2, 16'h10);
    wr(4'h5, 32'h13);
    wr(4'hD, 32'h17);
    wait_done(1);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all rows written", exp_q.size(), 0);
    rd(4'hE, v); chk(v == 32'd1, "R8 store done not busy", v, 1);
    chk(irq_o[1] == 1'b1, "R10 irq high with done", irq_o, 2'b11);
    chk(wr_size_o == 2'd1, "R1 store size code", wr_size_o, 1);
    clr();
    chk(irq_o == 2'b00, "R8 R10 W1C clears", irq_o, 0);

    // R3 one-dimensional, row count 0 and row step ignored
    gen(0, 32'h500, 4, 16'd2, 7, 16'h100, 0);
    gen(1, 32'h600, 4, 16'd2, 0, 16'h40, 0);
    pair();
    prog(0, 32'h500, 4, 2, 7, 16'h100);
    prog(1, 32'h600, 4, 2, 0, 16'h40);
    wr(4'h5, 32'h11);
    wr(4'hD, 32'h15);
    wait_done(1);
    repeat (2) @(negedge clk_i);
    rd(4'hE, v); chk(v == 32'd1, "R3 single row done no error", v, 1);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    clr();

    // R4 negative steps with wrap
    gen(0, 32'h4, 3, 16'hFFFC, 1, 16'hFFFC, 0);
    gen(1, 32'h0, 3, 16'hFFFC, 1, 16'hFFFC, 0);
    pair();
    prog(0, 32'h4, 3, 16'hFFFC, 1, 16'hFFFC);
    prog(1, 32'h0, 3, 16'hFFFC, 1, 16'hFFFC);
    wr(4'h5, 32'h21);
    wr(4'hD, 32'h25);
    wait_done(1);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R4 wrap writes seen", exp_q.size(), 0);
    clr();

    // R6 refusals
    w0 = n_wr;
    prog(0, 32'h100, 0, 2, 1, 2);
    wr(4'h5, 32'h11);
    repeat (4) @(negedge clk_i);
    rd(4'h6, v); chk(v == 32'd2, "R6 zero inner count error", v, 2);
    wr(4'h6, 32'd2);
    rd(4'h6, v); chk(v == 32'd0, "R8 error W1C", v, 0);
    prog(0, 32'h100, 2, 2, 0, 2);
    wr(4'h5, 32'h13);
    rd(4'h6, v); chk(v == 32'd2, "R6 zero row count 2D error", v, 2);
    wr(4'h6, 32'd2);
    prog(0, 32'h101, 2, 2, 1, 2);
    wr(4'h5, 32'h11);
    rd(4'h6, v); chk(v == 32'd2, "R6 misaligned base error", v, 2);
    wr(4'h6, 32'd2);
    prog(0, 32'h100, 2, 2, 1, 2);
    wr(4'h5, 32'h15);
    rd(4'h6, v); chk(v == 32'd2, "R6 direction mismatch error", v, 2);
    wr(4'h6, 32'd2);
    wr(4'h5, 32'h31);
    rd(4'h6, v); chk(v == 32'd2, "R6 size 3 error", v, 2);
    wr(4'h6, 32'd2);
    repeat (4) @(negedge clk_i);
    chk(n_wr == w0 && !rd_req_o, "R6 no data moved", n_wr, w0);

    // R7 control write while busy
    gen(0, 32'h200, 8, 16'd4, 1, 16'd4, 0);
    gen(1, 32'h3000, 8, 16'd4, 1, 16'd4, 0);
    pair();
    prog(0, 32'h200, 8, 4, 1, 4);
    wr(4'h5, 32'h21);
    repeat (10) @(negedge clk_i);
    wr(4'h5, 32'h23);
    wr(4'h0, 32'h900);
    rd(4'h6, v); chk(v == 32'd6, "R7 busy with error", v, 6);
    rd(4'h5, v); chk(v == 32'h21, "R7 ctrl unchanged", v, 32'h21);
    rd(4'h0, v); chk(v == 32'h200, "R7 base unchanged", v, 32'h200);
    prog(1, 32'h3000, 8, 4, 1, 4);
    wr(4'hD, 32'h25);
    wait_done(1);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 original transfer completes", exp_q.size(), 0);
    rd(4'h6, v); chk(v == 32'd3, "R7 fetch done with error kept", v, 3);
    clr();

    // R9 completion and clear in the same cycle
    gen(0, 32'h40, 1, 16'd4, 1, 16'd4, 0);
    gen(1, 32'h80, 1, 16'd4, 1, 16'd4, 0);
    pair();
    prog(0, 32'h40, 1, 4, 1, 4);
    prog(1, 32'h80, 1, 4, 1, 4);
    wr(4'h5, 32'h21);
    repeat (5) @(negedge clk_i);
    wr(4'hD, 32'h25);
    wr(4'hE, 32'd3);
    rd(4'hE, v); chk(v == 32'd1, "R9 set wins over clear", v, 1);
    chk(irq_o[1] == 1'b1, "R9 R10 irq stays", irq_o, 2'b11);
    wr(4'hE, 32'd1);
    rd(4'hE, v); chk(v == 32'd0, "R9 later clear works", v, 0);
    chk(irq_o[1] == 1'b0, "R10 irq drops", irq_o, 0);
    chk(exp_q.size() == 0, "R5 single element written", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule